// File: doc/BRIEF.md
# Flag-Synchronized Pipeline Front-End Controller

This block is the control skeleton of the front of a pipelined processor. Three cooperating state machines form it: a fetch stage, a first operand stage and a second operand stage. They never exchange valid/ready pulses. Instead they share four persistent single-bit flags: first-stage busy, second-stage busy, branch-checked and branch-in-progress. Each machine polls these flags in dedicated wait states. A flag keeps its value until some stage writes a different one.

Fetch reads one instruction word and its two-bit class from a memory port that always answers. It then hands the word to a downstream stage by writing that stage's private instruction copy and raising the stage's busy flag in the same cycle. It does this only once the flag has dropped, so a pending copy is never overwritten. A branch goes straight to the second operand stage. That stage raises branch-checked and branch-in-progress together, then clears branch-in-progress and its own busy flag, and zeroes its copy. Fetch stalls until the branch has been checked and is no longer in progress. The block signals a redirect when a branch is checked while the branch-taken condition is high.

Class encoding on `cls_i`: 0 = first operand stage only, 1 = first then second operand stage, 2 = second operand stage only (the first is skipped), 3 = branch (second operand stage only).

Top module: `flagpipe_front`

## Requirements
- R1: While `rst_n` is low, `op1_done_o`, `op2_done_o` and `redirect_o` are 0, and all three instruction copies read 0. After reset all four flags are 0.
- R2: Every fetched instruction of class 0 or 1 is reported exactly once by `op1_done_o`, with `ir_op1_o` equal to its word, in fetch order.
- R3: Every fetched instruction of class 1, 2 or 3 is reported exactly once by `op2_done_o`, with `ir_op2_o` equal to its word, in fetch order. This holds even when direct and first-stage hand-offs are interleaved.
- R4: Take a class-2 instruction fetched from idle in cycle F, with both busy flags clear. `ir_op2_o` shows its word in cycle F+2, and `op2_done_o` pulses in cycle F+3+OP2_LAT.
- R5: In the cycle after `op2_done_o`, `ir_op2_o` reads 0.
- R6: Once a branch (class 3) is fetched, `fetch_o` stays low until its `op2_done_o`. The next fetch then occurs exactly two cycles after that done pulse.
- R7: `redirect_o` pulses exactly in the cycle before the `op2_done_o` of a branch, and only when `br_taken_i` is high in that cycle. It stays low at all other times.
- R8: An instruction copy is written only while its stage's busy flag is 0. No instruction is lost or duplicated.
- R9: Fetch waiting for branch-checked and the second operand stage idling at its start state never overlap for more than DL_BOUND cycles. Every instruction stream therefore drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | IW | Instruction word presented by memory |
| cls_i | input | 2 | Class of `instr_i` (encoding above) |
| br_taken_i | input | 1 | Branch condition, sampled when a branch is checked |
| fetch_o | output | 1 | Fetch consumes `instr_i`/`cls_i` this cycle |
| op1_done_o | output | 1 | First operand stage completes the instruction in `ir_op1_o` |
| op2_done_o | output | 1 | Second operand stage completes the instruction in `ir_op2_o` |
| ir_fe_o | output | IW | Fetch stage instruction copy |
| ir_op1_o | output | IW | First operand stage instruction copy |
| ir_op2_o | output | IW | Second operand stage instruction copy |
| redirect_o | output | 1 | Branch redirect request pulse |

## Verification
A flag stuck high or raised too early shows at the ports within a few cycles. Either a done strobe carries the wrong word or arrives out of fetch order, or a copy is overwritten so a word never completes. A lost branch-checked or branch-in-progress update either freezes `fetch_o`, which ends the run at the watchdog, or lets a fetch slip in while a branch is still pending, which the branch-gap check sees on the very next `fetch_o`. A wrong copy-clearing or redirect timing is caught in the one cycle around the second stage's done pulse.

// File: rtl/flagpipe_pkg.sv
package flagpipe_pkg;

    typedef enum logic [1:0] {
        CLS_OP1  = 2'd0,
        CLS_OP12 = 2'd1,
        CLS_OP2  = 2'd2,
        CLS_BR   = 2'd3
    } icls_e;

    localparam int NFLAG   = 4;
    localparam int FL_B1   = 0;
    localparam int FL_B2   = 1;
    localparam int FL_CHK  = 2;
    localparam int FL_BIP  = 3;

    typedef enum logic [2:0] {
        FE_GET = 3'd0,
        FE_TO1 = 3'd1,
        FE_TO2 = 3'd2,
        FE_CHK = 3'd3,
        FE_BIP = 3'd4
    } fe_st_e;

    typedef enum logic [1:0] {
        O1_IDLE = 2'd0,
        O1_WORK = 2'd1,
        O1_FIN  = 2'd2
    } o1_st_e;

    typedef enum logic [1:0] {
        O2_IDLE = 2'd0,
        O2_WORK = 2'd1,
        O2_BSET = 2'd2,
        O2_FIN  = 2'd3
    } o2_st_e;

    function automatic logic goes_op1(icls_e c);
        return (c == CLS_OP1) || (c == CLS_OP12);
    endfunction

endpackage

// File: rtl/fp_flags.sv
module fp_flags
    import flagpipe_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] q_o
);
    logic [NF-1:0] q_d, q_q;

    // a clear request outranks a set request on the same flag
    always_comb begin
        for (int i = 0; i < NF; i++) begin
            if (clr_i[i])      q_d[i] = 1'b0;
            else if (set_i[i]) q_d[i] = 1'b1;
            else               q_d[i] = q_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R1
    flags_reset_chk: assert property (@(posedge clk) !rst_n |=> (q_q == '0));
endmodule

// File: rtl/fp_fetch.sv
module fp_fetch
    import flagpipe_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    instr_i,
    input  icls_e            cls_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic             fetch_o,
    output logic [NFLAG-1:0] set_o,
    output logic [NFLAG-1:0] clr_o,
    output logic             wr1_o,
    output logic             wr2_o,
    output logic [IW-1:0]    ir_o,
    output icls_e            cls_o,
    output logic             brwait_o
);
    typedef struct packed {
        fe_st_e        st;
        logic [IW-1:0] ir;
        icls_e         cls;
    } fe_t;

    fe_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        fetch_o = 1'b0;
        set_o   = '0;
        clr_o   = '0;
        wr1_o   = 1'b0;
        wr2_o   = 1'b0;
        case (r_q.st)
            FE_GET: begin
                fetch_o  = 1'b1;
                r_d.ir   = instr_i;
                r_d.cls  = cls_i;
                r_d.st   = goes_op1(cls_i) ? FE_TO1 : FE_TO2;
            end
            FE_TO1: begin
                if (!flags_i[FL_B1]) begin
                    set_o[FL_B1] = 1'b1;
                    wr1_o        = 1'b1;
                    r_d.st       = FE_GET;
                end
            end
            FE_TO2: begin
                // first stage must be empty too, so order into stage two is kept
                if (!flags_i[FL_B1] && !flags_i[FL_B2]) begin
                    set_o[FL_B2] = 1'b1;
                    wr2_o        = 1'b1;
                    r_d.st       = (r_q.cls == CLS_BR) ? FE_CHK : FE_GET;
                end
            end
            FE_CHK: begin
                if (flags_i[FL_CHK]) begin
                    clr_o[FL_CHK] = 1'b1;
                    r_d.st        = FE_BIP;
                end
            end
            FE_BIP: begin
                if (!flags_i[FL_BIP]) r_d.st = FE_GET;
            end
            default: r_d.st = FE_GET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ir_o     = r_q.ir;
    assign cls_o    = r_q.cls;
    assign brwait_o = (r_q.st == FE_CHK);

    // R6
    fetch_no_bip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> !flags_i[FL_BIP]);
endmodule

// File: rtl/fp_op1.sv
module fp_op1
    import flagpipe_pkg::*;
#(
    parameter int IW  = 16,
    parameter int LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy1_i,
    input  logic             busy2_i,
    input  logic             wr_i,
    input  logic [IW-1:0]    ir_i,
    input  icls_e            cls_i,
    output logic [NFLAG-1:0] set_o,
    output logic [NFLAG-1:0] clr_o,
    output logic             wr2_o,
    output logic [IW-1:0]    ir_o,
    output icls_e            cls_o,
    output logic             done_o
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 1);

    typedef struct packed {
        o1_st_e        st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] ir;
        icls_e         cls;
    } o1_t;

    o1_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        set_o  = '0;
        clr_o  = '0;
        wr2_o  = 1'b0;
        done_o = 1'b0;
        if (wr_i) begin
            r_d.ir  = ir_i;
            r_d.cls = cls_i;
        end
        case (r_q.st)
            O1_IDLE: begin
                if (busy1_i) begin
                    r_d.st  = O1_WORK;
                    r_d.cnt = '0;
                end
            end
            O1_WORK: begin
                if (r_q.cnt == CNT_LAST) r_d.st  = O1_FIN;
                else                     r_d.cnt = r_q.cnt + 1'b1;
            end
            O1_FIN: begin
                if (r_q.cls == CLS_OP12) begin
                    if (!busy2_i) begin
                        set_o[FL_B2] = 1'b1;
                        wr2_o        = 1'b1;
                        clr_o[FL_B1] = 1'b1;
                        done_o       = 1'b1;
                        r_d.st       = O1_IDLE;
                    end
                end else begin
                    clr_o[FL_B1] = 1'b1;
                    done_o       = 1'b1;
                    r_d.st       = O1_IDLE;
                end
            end
            default: r_d.st = O1_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ir_o  = r_q.ir;
    assign cls_o = r_q.cls;

    // R8
    op1_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !busy1_i);
endmodule

// File: rtl/fp_op2.sv
module fp_op2
    import flagpipe_pkg::*;
#(
    parameter int IW  = 16,
    parameter int LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy2_i,
    input  logic             wr_fe_i,
    input  logic [IW-1:0]    ir_fe_i,
    input  icls_e            cls_fe_i,
    input  logic             wr_o1_i,
    input  logic [IW-1:0]    ir_o1_i,
    input  icls_e            cls_o1_i,
    input  logic             br_taken_i,
    output logic [NFLAG-1:0] set_o,
    output logic [NFLAG-1:0] clr_o,
    output logic [IW-1:0]    ir_o,
    output logic             done_o,
    output logic             redirect_o,
    output logic             idle_o,
    output logic             holds_br_o
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 1);

    typedef struct packed {
        o2_st_e        st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] ir;
        icls_e         cls;
    } o2_t;

    o2_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        set_o      = '0;
        clr_o      = '0;
        done_o     = 1'b0;
        redirect_o = 1'b0;
        case (r_q.st)
            O2_IDLE: begin
                if (busy2_i) begin
                    r_d.st  = O2_WORK;
                    r_d.cnt = '0;
                end
            end
            O2_WORK: begin
                if (r_q.cnt == CNT_LAST)
                    r_d.st = (r_q.cls == CLS_BR) ? O2_BSET : O2_FIN;
                else
                    r_d.cnt = r_q.cnt + 1'b1;
            end
            O2_BSET: begin
                set_o[FL_CHK] = 1'b1;
                set_o[FL_BIP] = 1'b1;
                redirect_o    = br_taken_i;
                r_d.st        = O2_FIN;
            end
            O2_FIN: begin
                clr_o[FL_BIP] = 1'b1;
                clr_o[FL_B2]  = 1'b1;
                done_o        = 1'b1;
                r_d.ir        = '0;
                r_d.cls       = CLS_OP1;
                r_d.st        = O2_IDLE;
            end
            default: r_d.st = O2_IDLE;
        endcase
        if (wr_fe_i) begin
            r_d.ir  = ir_fe_i;
            r_d.cls = cls_fe_i;
        end else if (wr_o1_i) begin
            r_d.ir  = ir_o1_i;
            r_d.cls = cls_o1_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ir_o       = r_q.ir;
    assign idle_o     = (r_q.st == O2_IDLE);
    assign holds_br_o = (r_q.cls == CLS_BR);

    // R3
    op2_single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_fe_i, wr_o1_i}));
    // R8
    op2_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fe_i || wr_o1_i) |-> !busy2_i);
    // R5
    op2_zero_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (ir_o == '0));
    // R7
    redirect_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (holds_br_o && br_taken_i));
endmodule

// File: rtl/flagpipe_front.sv
module flagpipe_front
    import flagpipe_pkg::*;
#(
    parameter int IW       = 16,
    parameter int OP1_LAT  = 2,
    parameter int OP2_LAT  = 2,
    parameter int DL_BOUND = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_i,
    input  logic [1:0]    cls_i,
    input  logic          br_taken_i,
    output logic          fetch_o,
    output logic          op1_done_o,
    output logic          op2_done_o,
    output logic [IW-1:0] ir_fe_o,
    output logic [IW-1:0] ir_op1_o,
    output logic [IW-1:0] ir_op2_o,
    output logic          redirect_o
);
    localparam int DLW = $clog2(DL_BOUND + 1);
    localparam logic [DLW-1:0] DL_LIM = DLW'(DL_BOUND);

    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] fe_set, fe_clr, o1_set, o1_clr, o2_set, o2_clr;
    logic             fe_wr1, fe_wr2, o1_wr2;
    icls_e            fe_cls, o1_cls;
    logic             fe_brwait, o2_idle, o2_holds_br;

    fp_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fe_set | o1_set | o2_set),
        .clr_i (fe_clr | o1_clr | o2_clr),
        .q_o   (flags_q)
    );

    fp_fetch #(.IW(IW)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_i  (instr_i),
        .cls_i    (icls_e'(cls_i)),
        .flags_i  (flags_q),
        .fetch_o  (fetch_o),
        .set_o    (fe_set),
        .clr_o    (fe_clr),
        .wr1_o    (fe_wr1),
        .wr2_o    (fe_wr2),
        .ir_o     (ir_fe_o),
        .cls_o    (fe_cls),
        .brwait_o (fe_brwait)
    );

    fp_op1 #(.IW(IW), .LAT(OP1_LAT)) u_op1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy1_i (flags_q[FL_B1]),
        .busy2_i (flags_q[FL_B2]),
        .wr_i    (fe_wr1),
        .ir_i    (ir_fe_o),
        .cls_i   (fe_cls),
        .set_o   (o1_set),
        .clr_o   (o1_clr),
        .wr2_o   (o1_wr2),
        .ir_o    (ir_op1_o),
        .cls_o   (o1_cls),
        .done_o  (op1_done_o)
    );

    fp_op2 #(.IW(IW), .LAT(OP2_LAT)) u_op2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy2_i    (flags_q[FL_B2]),
        .wr_fe_i    (fe_wr2),
        .ir_fe_i    (ir_fe_o),
        .cls_fe_i   (fe_cls),
        .wr_o1_i    (o1_wr2),
        .ir_o1_i    (ir_op1_o),
        .cls_o1_i   (o1_cls),
        .br_taken_i (br_taken_i),
        .set_o      (o2_set),
        .clr_o      (o2_clr),
        .ir_o       (ir_op2_o),
        .done_o     (op2_done_o),
        .redirect_o (redirect_o),
        .idle_o     (o2_idle),
        .holds_br_o (o2_holds_br)
    );

    // mutual-wait watch: fetch waiting on branch-checked while stage two idles
    logic [DLW-1:0] dl_d, dl_q;

    always_comb begin
        dl_d = '0;
        if (fe_brwait && o2_idle)
            dl_d = (dl_q == DL_LIM) ? dl_q : dl_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    // R9
    no_deadlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_q < DL_LIM);
    // R6
    brwait_has_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fe_brwait |-> o2_holds_br);
    // R8
    op1_busy_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_B1]) |-> $past(fe_wr1));
    // R8
    op2_busy_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_B2]) |-> ($past(fe_wr2) || $past(o1_wr2)));
endmodule

// File: tb/flagpipe_front_bench.sv
module flagpipe_front_bench;
    localparam int IW  = 16;
    localparam int L1  = 2;
    localparam int L2  = 2;
    localparam int N   = 240;
    localparam int PN  = N + 64;
    localparam int WD  = 40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [IW-1:0] instr_i, ir_fe_o, ir_op1_o, ir_op2_o;
    logic [1:0]    cls_i;
    logic          br_taken_i, fetch_o, op1_done_o, op2_done_o, redirect_o;

    logic [IW-1:0] pw [PN];
    logic [1:0]    pc [PN];
    int            fcyc [PN];
    int            e1 [N];
    int            e2 [N];
    int n1 = 0, n2 = 0, j1 = 0, j2 = 0, k = 0, drv = 0, cyc = 0;
    int checks = 0, fails = 0;
    int zchk_at = -1, last_br_done = -1;
    bit br_pend = 0, prev_red = 0, run = 0, have0 = 0;

    flagpipe_front #(.IW(IW), .OP1_LAT(L1), .OP2_LAT(L2), .DL_BOUND(8)) u_flagpipe_front (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cls_i(cls_i),
        .br_taken_i(br_taken_i), .fetch_o(fetch_o), .op1_done_o(op1_done_o),
        .op2_done_o(op2_done_o), .ir_fe_o(ir_fe_o), .ir_op1_o(ir_op1_o),
        .ir_op2_o(ir_op2_o), .redirect_o(redirect_o)
    );

    assign instr_i    = pw[drv];
    assign cls_i      = pc[drv];
    assign br_taken_i = ir_op2_o[0];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n)                 drv <= 0;
        else if (fetch_o && drv < PN - 1) drv <= drv + 1;
    end

    always @(negedge clk) begin
        if (rst_n && run) begin
            if (cyc == zchk_at)
                chk(ir_op2_o == '0, "R5 copy zero after done", ir_op2_o, 0);
            if (prev_red && !op2_done_o)
                chk(1'b0, "R7 stray redirect", 1, 0);
            if (have0 && cyc == fcyc[0] + 2)
                chk(ir_op2_o == pw[0], "R4 copy timing", ir_op2_o, pw[0]);
            if (fetch_o && k < PN) begin
                if (br_pend) chk(1'b0, "R6 fetch during branch", cyc, 0);
                if (last_br_done >= 0) begin
                    chk(cyc == last_br_done + 2, "R6 fetch gap", cyc, last_br_done + 2);
                    last_br_done = -1;
                end
                fcyc[k] = cyc;
                if (k == 0) have0 = 1;
                if (k < N && pc[k] == 2'd3) br_pend = 1;
                k++;
            end
            if (op2_done_o) begin
                if (j2 < n2) begin
                    chk(ir_op2_o == pw[e2[j2]], "R3 stage-two order", ir_op2_o, pw[e2[j2]]);
                    if (e2[j2] == 0)
                        chk(cyc == fcyc[0] + 3 + L2, "R4 done timing", cyc, fcyc[0] + 3 + L2);
                    if (pc[e2[j2]] == 2'd3) begin
                        chk(prev_red == pw[e2[j2]][0], "R7 redirect", prev_red, pw[e2[j2]][0]);
                        br_pend = 0;
                        last_br_done = cyc;
                    end else begin
                        chk(!prev_red, "R7 redirect on non-branch", prev_red, 0);
                    end
                    j2++;
                end
                zchk_at = cyc + 1;
            end
            if (op1_done_o && j1 < n1) begin
                chk(ir_op1_o == pw[e1[j1]], "R2 stage-one order", ir_op1_o, pw[e1[j1]]);
                j1++;
            end
            prev_red = redirect_o;
        end
    end

    initial begin
        int p;
        // directed head: direct stage-two instruction, then a taken branch
        pw[0] = 16'hA000; pc[0] = 2'd2;
        pw[1] = 16'hB003; pc[1] = 2'd3;
        p = 2;
        // every ordered pair of classes
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                pc[p] = 2'(a); pc[p + 1] = 2'(b); p += 2;
            end
        end
        for (int i = p; i < N; i++) pc[i] = 2'($urandom_range(0, 3));
        for (int i = 2; i < N; i++)
            pw[i] = 16'((i * 16'd37 + 16'd8) & 16'hFFFE) | 16'($urandom_range(0, 1));
        for (int i = N; i < PN; i++) begin pw[i] = 16'hFFFE; pc[i] = 2'd0; end
        for (int i = 0; i < N; i++) begin
            if (pc[i] <= 2'd1) begin e1[n1] = i; n1++; end
            if (pc[i] >= 2'd1) begin e2[n2] = i; n2++; end
        end

        repeat (3) @(negedge clk);
        // R1
        chk(!op1_done_o && !op2_done_o && !redirect_o, "R1 strobes in reset",
            {op1_done_o, op2_done_o, redirect_o}, 0);
        chk(ir_fe_o == '0 && ir_op1_o == '0 && ir_op2_o == '0, "R1 copies in reset",
            ir_fe_o | ir_op1_o | ir_op2_o, 0);
        @(posedge clk);
        #1 rst_n = 1'b1; run = 1;

        while (!(j1 == n1 && j2 == n2) && cyc < WD) @(negedge clk);
        repeat (4) @(negedge clk);
        // R9
        chk(cyc < WD, "R9 stream drained", cyc, WD);
        // R8
        chk(j1 == n1, "R8 stage-one count", j1, n1);
        chk(j2 == n2, "R8 stage-two count", j2, n2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule